// File: doc/BRIEF.md
# Serial ADC Command Front End

This block is the digital face of a multiplexed 8-bit analog-to-digital converter, seen from a serial peripheral bus as a slave. Every byte the host shifts in is also a byte shifted out. Some incoming bytes are commands: they pick an input channel and a measurement style, and they compute a result from sample registers. The following exchanges hand the result back in two pieces. There is no analog path. A parallel load port on the chip side holds the per-channel sample values and a common reference value. The block samples the SPI lines with its own system clock.

A command byte has its top bit set. It chooses a channel, single-ended or differential measurement, and unipolar or bipolar coding. It can also put the converter into a sleep state. Each accepted command that keeps the converter awake raises a one-cycle conversion pulse. It also sets a sticky interrupt flag, which the chip clears through a dedicated input. The parameter `NUM_CH` selects either an eight-channel or a four-channel build. The two builds map the select field to a channel differently.

Top module: `adc_ctrl_frontend`

## Requirements
- R1: After reset, channel `k` holds 0xF0 - 16*k, the reference holds 0x00, the converter is asleep, and every byte returned is 0x00. `conv_pulse` and `conv_irq` are low.
- R2: A received byte with bit 7 clear is not a command. It raises no pulse, it does not wake the converter, and it does not disturb the stored result or the sleep state.
- R3: A byte with bit 7 set restarts the response sequence at position 0. If bit 1 of that byte is clear, the converter sleeps: every later returned byte is 0x00 and no pulse is raised.
- R4: With `NUM_CH`=8, the channel index is {bit5, bit4, bit6} of the command, with bit5 as the most significant bit.
- R5: With `NUM_CH`=4, bit 4 of the command is ignored and the channel index is {bit5, bit6}.
- R6: When bit 2 of the command is set (single-ended), the measurement is sample[ch] minus the reference, taken modulo 256.
- R7: When bit 2 is clear (differential), the measurement is sample[ch] minus sample[ch XOR 1], taken modulo 256.
- R8: When bit 3 of the command is clear (bipolar), bit 7 of the measurement is inverted before it is returned.
- R9: Each received byte selects a response by its sequence position, and the position then advances. Position 0 gives 0x00, position 1 gives {2'b00, m[7:2]}, position 2 gives {m[1:0], 6'b0}, and higher positions give 0x00. The response is shifted out MSB first, in mode 0, during the next exchange.
- R10: Each accepted waking command gives a `conv_pulse` exactly one clock wide and sets `conv_irq`. `irq_clr` clears `conv_irq`. When a set and a clear fall in the same cycle, the set wins.
- R11: A write with `smp_wr_en` high loads `smp_wr_data` into channel `smp_wr_addr`, or into the reference when the address is `NUM_CH`. A conversion in the same cycle as the write uses the value held before the write.
- R12: Raising `spi_cs_n` in the middle of a byte discards the partial byte. The sequence position, the stored result and the pending response are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it samples the SPI lines |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select that frames the bytes |
| spi_mosi | input | 1 | Serial data from the host, MSB first |
| spi_miso | output | 1 | Serial data to the host, MSB first |
| smp_wr_en | input | 1 | Write strobe for a sample register |
| smp_wr_addr | input | $clog2(NUM_CH+1) | Channel index, or NUM_CH for the reference |
| smp_wr_data | input | 8 | Sample value to store |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| conv_pulse | output | 1 | One-cycle pulse for each accepted conversion |
| conv_irq | output | 1 | Sticky conversion interrupt flag |

## Verification
Two events can land on the same clock edge: a parallel sample write and the acceptance of a command that reads that same sample. The interrupt clear and the interrupt set can also coincide. The bench provokes both collisions by counting system clocks from the final serial-clock rise, through the input synchronizer and the byte register. It then raises `smp_wr_en` or `irq_clr` for exactly the acceptance cycle. The write collision passes when the returned result matches the pre-write sample and a later conversion shows the new one. The clear collision passes when `conv_irq` stays high.

// File: rtl/adc_fe_pkg.sv
// Package adc_fe_pkg
// Shared types and reset values for the serial ADC front end.
// Assumes 8-bit samples; only the channel count varies between builds.
package adc_fe_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Command byte; bit positions are fixed by the serial protocol
    typedef struct packed {
        logic start;   // bit 7: marks the byte as a command
        logic sel2;    // bit 6
        logic sel1;    // bit 5
        logic sel0;    // bit 4
        logic uni;     // bit 3: unipolar coding when set
        logic sgl;     // bit 2: single-ended when set
        logic pd1;     // bit 1: converter stays awake when set
        logic pd0;     // bit 0: carries no function here
    } cmd_t;

    // Reset value of a channel: steps down by 0x10 from 0xF0
    function automatic byte_t reset_sample(input int idx);
        return byte_t'(240 - idx * 16);
    endfunction

endpackage

// File: rtl/adc_spi_byte_if.sv
// Module adc_spi_byte_if
// Oversampled SPI mode-0 slave byte shifter. It synchronizes SCLK, CS_n and
// MOSI into clk, assembles MSB-first bytes on SCLK rises, and shifts the
// loaded response out on SCLK falls.
// Assumes clk runs at least about 8x faster than SCLK. While CS_n is high
// the bit counter stays at zero and the response shifter follows tx_byte.
module adc_spi_byte_if
    import adc_fe_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sclk,
    input  logic  cs_n,
    input  logic  mosi,
    input  logic  tx_load,
    input  byte_t tx_byte,
    output logic  miso,
    output logic  rx_valid,
    output byte_t rx_byte
);

    localparam int BIT_W = $clog2(BYTE_W);

    logic [SYNC_DEPTH:0]   sclk_q;
    logic [SYNC_DEPTH-1:0] cs_q;
    logic [SYNC_DEPTH-1:0] mosi_q;
    logic [BIT_W-1:0]      bit_cnt;
    logic [BYTE_W-2:0]     rx_sh;
    byte_t                 tx_sh;
    logic                  cs_act, sclk_rise, sclk_fall, mosi_bit;

    // Bring the asynchronous SPI lines into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[SYNC_DEPTH-1:0], sclk};
            cs_q   <= {cs_q[SYNC_DEPTH-2:0], cs_n};
            mosi_q <= {mosi_q[SYNC_DEPTH-2:0], mosi};
        end
    end

    assign cs_act    = ~cs_q[SYNC_DEPTH-1];
    assign sclk_rise =  sclk_q[SYNC_DEPTH-1] & ~sclk_q[SYNC_DEPTH];
    assign sclk_fall = ~sclk_q[SYNC_DEPTH-1] &  sclk_q[SYNC_DEPTH];
    assign mosi_bit  =  mosi_q[SYNC_DEPTH-1];

    // Assemble incoming bits; deselect drops any partial byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_bit};
                if (bit_cnt == BIT_W'(BYTE_W - 1)) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sh, mosi_bit};
                end
            end
        end
    end

    // Hold the response MSB on MISO and advance it between bit periods
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (tx_load || !cs_act) begin
            tx_sh <= tx_byte;
        end else if (sclk_fall && bit_cnt != '0) begin
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
    end

    assign miso = tx_sh[BYTE_W-1];

    // R12: no byte completes while deselected
    p_idle_no_byte_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !rx_valid);

    // R12: deselect leaves the bit position at the byte boundary
    p_idle_bitcnt_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> bit_cnt == '0);

    // R12: deselect restores the pending response on the shifter
    p_idle_reload_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> tx_sh == $past(tx_byte));

endmodule

// File: rtl/adc_sample_bank.sv
// Module adc_sample_bank
// Per-channel sample registers and the common reference register, loaded
// through a parallel write port. The channels reset to a descending
// pattern and the reference resets to zero.
// Assumes address NUM_CH selects the reference. Addresses above that are
// not decoded.
module adc_sample_bank
    import adc_fe_pkg::*;
#(
    parameter  int NUM_CH = 8,
    localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  byte_t                          wr_data,
    output logic [NUM_CH-1:0][BYTE_W-1:0]  samples,
    output byte_t                          ref_val
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        // Load one channel register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                samples[g] <= reset_sample(g);
            end else if (wr_en && wr_addr == ADDR_W'(g)) begin
                samples[g] <= wr_data;
            end
        end

        // R11: an addressed write lands in its channel
        p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(g)) |=> samples[g] == $past(wr_data));
    end

    // Load the common reference register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_val <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(NUM_CH)) begin
            ref_val <= wr_data;
        end
    end

    // R11: a channel write leaves the reference alone
    p_ref_untouched_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_W'(NUM_CH)) |=> $stable(ref_val));

endmodule

// File: rtl/adc_conv_decode.sv
// Module adc_conv_decode
// Combinational command decode and arithmetic. It maps the select field to
// a channel for the chosen build, subtracts the reference or the paired
// channel, applies the coding, and splits the result into two bytes.
// Assumes NUM_CH is 4 or 8. All arithmetic wraps modulo 256.
module adc_conv_decode
    import adc_fe_pkg::*;
#(
    parameter  int NUM_CH = 8,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  cmd_t                           cmd,
    input  logic [NUM_CH-1:0][BYTE_W-1:0]  samples,
    input  byte_t                          ref_val,
    output byte_t                          res_hi,
    output byte_t                          res_lo
);

    logic [CH_W-1:0] chan;
    byte_t           minuend, subtrahend, measure;

    // Select-field mapping differs between the two builds
    if (NUM_CH == 8) begin : g_map8
        assign chan = {cmd.sel1, cmd.sel0, cmd.sel2};
    end else begin : g_map4
        assign chan = {cmd.sel1, cmd.sel2};
    end

    // Form the measurement and split it across two response bytes
    always_comb begin
        minuend    = samples[chan];
        subtrahend = cmd.sgl ? ref_val : samples[chan ^ CH_W'(1)];
        measure    = minuend - subtrahend;
        if (!cmd.uni) begin
            measure[BYTE_W-1] = ~measure[BYTE_W-1];
        end
        res_hi = {2'b00, measure[BYTE_W-1:2]};
        res_lo = {measure[1:0], 6'b000000};
    end

endmodule

// File: rtl/adc_ctrl_frontend.sv
// Module adc_ctrl_frontend
// Top of the serial ADC front end. It accepts command bytes, keeps the
// sleep state, the response position and the two result bytes, chooses
// each byte's response, and raises the conversion pulse and flag.
// Assumes one response of latency: the byte chosen for exchange k goes out
// on MISO during exchange k+1.
module adc_ctrl_frontend
    import adc_fe_pkg::*;
#(
    parameter  int NUM_CH     = 8,
    parameter  int SYNC_DEPTH = 2,
    localparam int ADDR_W     = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              smp_wr_en,
    input  logic [ADDR_W-1:0] smp_wr_addr,
    input  logic [7:0]        smp_wr_data,
    input  logic              irq_clr,
    output logic              conv_pulse,
    output logic              conv_irq
);

    localparam int POS_W = 2;

    logic                          rx_valid, resp_load, awake, awake_n;
    logic                          take_cmd, do_conv;
    byte_t                         rx_byte, resp_q, resp_n;
    byte_t                         rb_hi, rb_lo, hi_n, lo_n, dec_hi, dec_lo, ref_val;
    cmd_t                          cmd;
    logic [POS_W-1:0]              pos, pos_base, pos_n;
    logic [NUM_CH-1:0][BYTE_W-1:0] samples;

    adc_spi_byte_if #(.SYNC_DEPTH(SYNC_DEPTH)) u_spi (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk    (spi_sclk),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .tx_load (resp_load),
        .tx_byte (resp_q),
        .miso    (spi_miso),
        .rx_valid(rx_valid),
        .rx_byte (rx_byte)
    );

    adc_sample_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (smp_wr_en),
        .wr_addr(smp_wr_addr),
        .wr_data(smp_wr_data),
        .samples(samples),
        .ref_val(ref_val)
    );

    assign cmd = cmd_t'(rx_byte);

    adc_conv_decode #(.NUM_CH(NUM_CH)) u_dec (
        .cmd    (cmd),
        .samples(samples),
        .ref_val(ref_val),
        .res_hi (dec_hi),
        .res_lo (dec_lo)
    );

    // Apply the received byte first, then pick its response
    always_comb begin
        take_cmd = rx_valid && cmd.start;
        do_conv  = take_cmd && cmd.pd1;
        awake_n  = take_cmd ? cmd.pd1 : awake;
        pos_base = take_cmd ? '0 : pos;
        hi_n     = do_conv ? dec_hi : rb_hi;
        lo_n     = do_conv ? dec_lo : rb_lo;
        resp_n   = '0;
        if (awake_n) begin
            case (pos_base)
                POS_W'(1): resp_n = hi_n;
                POS_W'(2): resp_n = lo_n;
                default:   resp_n = '0;
            endcase
        end
        pos_n = pos_base;
        if (awake_n && pos_base != '1) begin
            pos_n = pos_base + 1'b1;
        end
    end

    // Commit the byte's effect on mode, position, results and response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            awake     <= 1'b0;
            pos       <= '0;
            rb_hi     <= '0;
            rb_lo     <= '0;
            resp_q    <= '0;
            resp_load <= 1'b0;
        end else begin
            resp_load <= rx_valid;
            if (rx_valid) begin
                awake  <= awake_n;
                pos    <= pos_n;
                rb_hi  <= hi_n;
                rb_lo  <= lo_n;
                resp_q <= resp_n;
            end
        end
    end

    // Conversion pulse and sticky flag; a set beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_pulse <= 1'b0;
            conv_irq   <= 1'b0;
        end else begin
            conv_pulse <= do_conv;
            if (do_conv) begin
                conv_irq <= 1'b1;
            end else if (irq_clr) begin
                conv_irq <= 1'b0;
            end
        end
    end

    // R3: a waking command restarts the sequence and consumes position 0
    p_restart_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_byte[7] && rx_byte[1]) |=> pos == POS_W'(1));

    // R3: a sleeping converter has nothing but zero queued
    p_sleep_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |-> resp_q == '0);

    // R2: a non-command byte raises no pulse
    p_nocmd_no_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_byte[7]) |=> !conv_pulse);

    // R2: a non-command byte keeps the sleep state
    p_nocmd_keeps_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_byte[7]) |=> awake == $past(awake));

    // R10: the pulse lasts a single cycle
    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        conv_pulse |=> !conv_pulse);

    // R10: the flag is up whenever the pulse is
    p_flag_with_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        conv_pulse |-> conv_irq);

endmodule

// File: tb/adc_ctrl_frontend_test.sv
module adc_ctrl_frontend_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, sclk, mosi, cs8_n, cs4_n, miso8, miso4;
    logic       wr8_en, wr4_en, irq_clr;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic       pulse8, irq8, pulse4, irq4;

    adc_ctrl_frontend #(.NUM_CH(8)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs8_n),
        .spi_mosi(mosi), .spi_miso(miso8), .smp_wr_en(wr8_en),
        .smp_wr_addr(wr_addr), .smp_wr_data(wr_data), .irq_clr(irq_clr),
        .conv_pulse(pulse8), .conv_irq(irq8)
    );

    adc_ctrl_frontend #(.NUM_CH(4)) uut4 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs4_n),
        .spi_mosi(mosi), .spi_miso(miso4), .smp_wr_en(wr4_en),
        .smp_wr_addr(wr_addr[2:0]), .smp_wr_data(wr_data), .irq_clr(irq_clr),
        .conv_pulse(pulse4), .conv_irq(irq4)
    );

    int   checks = 0, errors = 0, pulse_cnt = 0, pulse_long = 0;
    bit   done = 1'b0, last_p = 1'b0;
    logic [7:0] s8 [8];
    logic [7:0] s4 [4];
    logic [7:0] ref8 = 8'h00, ref4 = 8'h00;

    // Count conversion pulses and any pulse longer than one cycle
    always @(negedge clk) begin
        if (pulse8) pulse_cnt++;
        if (pulse8 && last_p) pulse_long++;
        last_p = pulse8;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // Expected {first, second} result bytes, computed from the requirements
    function automatic logic [15:0] expect_res(input bit w4, input logic [7:0] c);
        logic [2:0] ch;
        logic [7:0] m;
        if (w4) begin
            ch = {1'b0, c[5], c[6]};
            m  = s4[ch[1:0]] - (c[2] ? ref4 : s4[ch[1:0] ^ 2'd1]);
        end else begin
            ch = {c[5], c[4], c[6]};
            m  = s8[ch] - (c[2] ? ref8 : s8[ch ^ 3'd1]);
        end
        if (!c[3]) m = m ^ 8'h80;
        return {2'b00, m[7:2], m[1:0], 6'b000000};
    endfunction

    // One exchange of up to 8 bits; hook 1 or 2 fires in the acceptance cycle
    task automatic xfer(input bit w4, input logic [7:0] tx, input int nbits,
                        input int hook, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            mosi = tx[i];
            tick(6);
            rx[i] = w4 ? miso4 : miso8;
            sclk = 1'b1;
            if (i == 0 && hook != 0) begin
                tick(3);
                if (hook == 1) irq_clr = 1'b1; else wr8_en = 1'b1;
                tick(1);
                irq_clr = 1'b0;
                wr8_en  = 1'b0;
                tick(4);
            end else begin
                tick(8);
            end
            sclk = 1'b0;
            tick(8);
        end
    endtask

    task automatic select_dev(input bit w4);
        if (w4) cs4_n = 1'b0; else cs8_n = 1'b0;
        tick(4);
    endtask

    task automatic deselect_dev();
        cs8_n = 1'b1;
        cs4_n = 1'b1;
        tick(4);
    endtask

    task automatic write_smp(input bit w4, input int addr, input logic [7:0] d);
        wr_addr = 4'(addr);
        wr_data = d;
        if (w4) wr4_en = 1'b1; else wr8_en = 1'b1;
        tick(1);
        wr4_en = 1'b0;
        wr8_en = 1'b0;
        if (w4) begin
            if (addr == 4) ref4 = d; else s4[addr] = d;
        end else begin
            if (addr == 8) ref8 = d; else s8[addr] = d;
        end
    endtask

    // Command, then three dummy bytes that return 0x00, first byte, second byte
    task automatic convert(input bit w4, input logic [7:0] c, input string req);
        logic [7:0]  r;
        logic [15:0] e;
        e = expect_res(w4, c);
        select_dev(w4);
        xfer(w4, c, 8, 0, r);
        xfer(w4, 8'h00, 8, 0, r); chk("R9", "command own response", r, 8'h00);
        xfer(w4, 8'h00, 8, 0, r); chk(req, "first result byte", r, e[15:8]);
        xfer(w4, 8'h00, 8, 0, r); chk(req, "second result byte", r, e[7:0]);
        deselect_dev();
    endtask

    task automatic t_reset();
        logic [7:0] r;
        chk("R1", "conv_irq at reset", {7'd0, irq8}, 8'h00);
        chk("R1", "conv_pulse at reset", {7'd0, pulse8}, 8'h00);
        select_dev(0);
        xfer(0, 8'h00, 8, 0, r); chk("R1", "asleep byte 0", r, 8'h00);
        xfer(0, 8'h00, 8, 0, r); chk("R1", "asleep byte 1", r, 8'h00);
        deselect_dev();
        convert(0, 8'h8E, "R1");
        convert(0, 8'hFE, "R1");
    endtask

    task automatic t_map8();
        for (int s = 0; s < 8; s++) convert(0, 8'h8E | 8'(s << 4), "R4");
    endtask

    task automatic t_map4();
        for (int s = 0; s < 8; s++) convert(1, 8'h8E | 8'(s << 4), "R5");
    endtask

    task automatic t_single();
        write_smp(0, 5, 8'h47);
        write_smp(0, 8, 8'h12);
        convert(0, 8'hEE, "R11");
        write_smp(0, 5, 8'h10);
        write_smp(0, 8, 8'h20);
        convert(0, 8'hEE, "R6");
    endtask

    task automatic t_diff();
        write_smp(0, 2, 8'h35);
        write_smp(0, 3, 8'h50);
        convert(0, 8'h9A, "R7");
        convert(0, 8'hDA, "R7");
    endtask

    task automatic t_bipolar();
        convert(0, 8'hE6, "R8");
        convert(0, 8'h92, "R8");
    endtask

    task automatic t_nocmd();
        logic [7:0]  r;
        logic [15:0] e;
        int          p0;
        e  = expect_res(0, 8'hEE);
        p0 = pulse_cnt;
        select_dev(0);
        xfer(0, 8'hEE, 8, 0, r);
        xfer(0, 8'h7F, 8, 0, r); chk("R2", "zero after command", r, 8'h00);
        xfer(0, 8'h7F, 8, 0, r); chk("R2", "first byte kept", r, e[15:8]);
        xfer(0, 8'h7F, 8, 0, r); chk("R2", "second byte kept", r, e[7:0]);
        xfer(0, 8'h80, 8, 0, r); chk("R9", "position past two", r, 8'h00);
        xfer(0, 8'h7F, 8, 0, r); chk("R3", "sleep command response", r, 8'h00);
        xfer(0, 8'h7F, 8, 0, r); chk("R2", "still asleep 1", r, 8'h00);
        xfer(0, 8'h7F, 8, 0, r); chk("R2", "still asleep 2", r, 8'h00);
        deselect_dev();
        chk("R2", "pulse count", 8'(pulse_cnt - p0), 8'd1);
    endtask

    task automatic t_restart();
        logic [7:0]  r;
        logic [15:0] e;
        e = expect_res(0, 8'hEE);
        select_dev(0);
        xfer(0, 8'hEE, 8, 0, r);
        xfer(0, 8'h00, 8, 0, r);
        xfer(0, 8'h00, 8, 0, r); chk("R3", "first before restart", r, e[15:8]);
        xfer(0, 8'hEE, 8, 0, r); chk("R3", "second before restart", r, e[7:0]);
        xfer(0, 8'h00, 8, 0, r); chk("R3", "restart own response", r, 8'h00);
        xfer(0, 8'h00, 8, 0, r); chk("R3", "first after restart", r, e[15:8]);
        deselect_dev();
    endtask

    task automatic t_irq();
        logic [7:0] r;
        int         p0;
        chk("R10", "flag after conversions", {7'd0, irq8}, 8'h01);
        p0 = pulse_cnt;
        select_dev(0);
        xfer(0, 8'hEE, 8, 1, r);
        deselect_dev();
        chk("R10", "set beats clear", {7'd0, irq8}, 8'h01);
        chk("R10", "one pulse per command", 8'(pulse_cnt - p0), 8'd1);
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(1);
        chk("R10", "flag cleared", {7'd0, irq8}, 8'h00);
        chk("R10", "pulses longer than one cycle", 8'(pulse_long), 8'd0);
    endtask

    task automatic t_collide();
        logic [7:0]  r;
        logic [15:0] e;
        e = expect_res(0, 8'hEE);
        wr_addr = 4'd5;
        wr_data = 8'h99;
        select_dev(0);
        xfer(0, 8'hEE, 8, 2, r);
        s8[5] = 8'h99;
        xfer(0, 8'h00, 8, 0, r);
        xfer(0, 8'h00, 8, 0, r); chk("R11", "collision uses old first", r, e[15:8]);
        xfer(0, 8'h00, 8, 0, r); chk("R11", "collision uses old second", r, e[7:0]);
        deselect_dev();
        convert(0, 8'hEE, "R11");
    endtask

    task automatic t_cs();
        logic [7:0]  r;
        logic [15:0] e;
        int          p0;
        e  = expect_res(0, 8'hEE);
        select_dev(0);
        xfer(0, 8'hEE, 8, 0, r);
        p0 = pulse_cnt;
        xfer(0, 8'h00, 8, 0, r);
        xfer(0, 8'hFF, 4, 0, r);
        deselect_dev();
        select_dev(0);
        xfer(0, 8'h00, 8, 0, r); chk("R12", "first after partial", r, e[15:8]);
        xfer(0, 8'h00, 8, 0, r); chk("R12", "second after partial", r, e[7:0]);
        deselect_dev();
        chk("R12", "partial byte raised no pulse", 8'(pulse_cnt - p0), 8'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) s8[i] = 8'(240 - i * 16);
        for (int i = 0; i < 4; i++) s4[i] = 8'(240 - i * 16);
        rst_n = 1'b0; sclk = 1'b0; mosi = 1'b0; cs8_n = 1'b1; cs4_n = 1'b1;
        wr8_en = 1'b0; wr4_en = 1'b0; irq_clr = 1'b0; wr_addr = '0; wr_data = '0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_map8();
        t_map4();
        t_single();
        t_diff();
        t_bipolar();
        t_nocmd();
        t_restart();
        t_irq();
        t_collide();
        t_cs();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule